// File: doc/BRIEF.md
# Asynchronous Static RAM Bus Controller

This block sits between a clocked host and an asynchronous static RAM with an 18-bit word address, a 16-bit data word split into two byte lanes, and active-low select, write-enable, output-enable and per-lane enable pins. The host offers one request at a time: an address, a write flag, write data and a two-bit lane mask. The controller turns it into a timed pin sequence. Every phase length is a whole number of clock cycles. Each length is worked out at elaboration from nanosecond minimums given in picoseconds, rounded up against the clock period.

The request port uses a valid/ready handshake with completion-style back-pressure. The host raises `req_valid` and holds it, together with every request field, until it sees `req_ready` high. `req_ready` is high for exactly one cycle, when the request has fully completed. For reads, `rsp_rdata` is valid in that same cycle. The host may present the next request in the cycle right after `req_ready`, or later. Data toward the memory leaves on `mem_dq_o` and is gated by `mem_dq_oe`. Data from the memory arrives on `mem_dq_i`.

Writes always keep output enable high, so the short write pulse is enough. The controller's data driver turns on only inside the write-enable pulse. After a read, a write waits out a guard interval so that the memory has released the bus before the controller drives it.

Top module: `sram_bus_ctrl`

## Requirements
- R1: While reset is asserted, and until the first request is accepted, `mem_cs_n`, `mem_we_n`, `mem_oe_n`, `mem_ub_n` and `mem_lb_n` are 1, `mem_dq_oe` is 0 and `req_ready` is 0.
- R2: `req_ready` is high for exactly one cycle per request, when the request completes. A request presented while the controller is idle is accepted on the next clock edge. With default timing, `req_ready` follows the accepting edge by 2 edges for a read, by 4 edges for a write and by 0 edges (same cycle after the edge) for a zero-mask request.
- R3: A read drives `mem_cs_n`=0, `mem_oe_n`=0, `mem_we_n`=1 and holds `mem_addr` equal to the request address for RD_CYC cycles (2 by default). Mask bit 1 maps to the upper lane (bits 15:8, `mem_ub_n`=0) and mask bit 0 maps to the lower lane (bits 7:0, `mem_lb_n`=0). The data is registered on the last read cycle and presented on `rsp_rdata` while `req_ready` is high.
- R4: In `rsp_rdata`, a lane whose mask bit is 0 reads as zero, whatever `mem_dq_i` carries on it.
- R5: A write holds `mem_oe_n`=1 throughout and keeps `mem_cs_n`=0 and `mem_addr` stable from one setup cycle before the pulse until one cycle after it. It drives `mem_we_n`=0 for exactly WP_CYC consecutive cycles (2 by default).
- R6: `mem_dq_oe` is 1 only in cycles where `mem_we_n` is 0 and was already 0 in the previous cycle. It falls in the same cycle that `mem_we_n` rises, so by default it is high for WP_CYC-1 = 1 cycle.
- R7: A write changes only the memory lanes whose mask bit is 1. The other lane keeps its earlier contents.
- R8: A request with mask 2'b00, read or write, completes without ever driving `mem_cs_n` low.
- R9: After a read has been accepted, a write with a nonzero mask waits TURN_CYC extra idle cycles (1 by default) before its setup cycle. At least TURN_CYC+1 deselected cycles lie between the last cycle with `mem_oe_n`=0 and the write setup cycle, and `mem_dq_oe` is never 1 in the cycle after one with `mem_oe_n`=0.
- R10: `mem_cs_n` is 1 in every cycle in which `req_ready` is 1, so the memory is deselected between requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present; held until `req_ready` |
| req_ready | output | 1 | One-cycle completion strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane mask: bit 1 upper byte, bit 0 lower byte |
| rsp_rdata | output | 16 | Read data, valid with `req_ready` |
| mem_addr | output | 18 | Memory address pins |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_ub_n | output | 1 | Upper lane enable, active low |
| mem_lb_n | output | 1 | Lower lane enable, active low |
| mem_dq_o | output | 16 | Data toward the memory |
| mem_dq_oe | output | 1 | Data driver enable for `mem_dq_o` |
| mem_dq_i | input | 16 | Data from the memory |

## Verification
All memory pins are registered. Each phase therefore shows up on the pins in the cycle after the edge that enters it, and the bench samples 1 ns after each falling edge, away from both edges. For every request, the bench counts falling edges from the moment the request is presented until `req_ready` is seen. It compares that count with a figure it computes: RD_CYC+1 for a read, WP_CYC+3 for a write and 1 for a zero-mask request, plus one when the request follows a completion back-to-back, plus any turnaround cycles still owed after a read. A cycle-by-cycle monitor measures the length of each write-enable pulse and each driver window when write enable rises. It also checks the address on every selected cycle and checks, at every write pulse start, the distance back to the last read cycle.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_READ,
    PH_WSETUP,
    PH_WPULSE,
    PH_WHOLD,
    PH_DONE
  } phase_e;

  // Minimum time in picoseconds rounded up to whole clock cycles.
  function automatic int unsigned cyc_ceil(input int unsigned t_ps, input int unsigned clk_ps);
    return (t_ps + clk_ps - 1) / clk_ps;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int unsigned W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/sram_lane_capture.sv
module sram_lane_capture #(
  parameter int unsigned LANES  = 2,
  parameter int unsigned LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cap_en,
  input  logic [LANES-1:0]        lane_en,
  input  logic [LANES*LANE_W-1:0] dq_in,
  output logic [LANES*LANE_W-1:0] data_out
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        data_out[g*LANE_W +: LANE_W] <= '0;
      else if (cap_en)
        data_out[g*LANE_W +: LANE_W] <= lane_en[g] ? dq_in[g*LANE_W +: LANE_W] : '0;
    end
  end

endmodule

// File: rtl/sram_pin_driver.sv
module sram_pin_driver
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W = 18,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  phase_e            phase_nxt,
  input  logic              pulse_first_nxt,
  input  logic [ADDR_W-1:0] addr_nxt,
  input  logic [DATA_W-1:0] wdata_nxt,
  input  logic [1:0]        mask_nxt,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic              mem_ub_n,
  output logic              mem_lb_n,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe
);

  logic sel_d, rd_d, pulse_d, drv_d;

  always_comb begin
    sel_d   = (phase_nxt == PH_READ)   || (phase_nxt == PH_WSETUP) ||
              (phase_nxt == PH_WPULSE) || (phase_nxt == PH_WHOLD);
    rd_d    = (phase_nxt == PH_READ);
    pulse_d = (phase_nxt == PH_WPULSE);
    drv_d   = pulse_d && !pulse_first_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr  <= '0;
      mem_cs_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_ub_n  <= 1'b1;
      mem_lb_n  <= 1'b1;
      mem_dq_o  <= '0;
      mem_dq_oe <= 1'b0;
    end else begin
      mem_addr  <= addr_nxt;
      mem_cs_n  <= !sel_d;
      mem_oe_n  <= !rd_d;
      mem_we_n  <= !pulse_d;
      mem_ub_n  <= !(sel_d && mask_nxt[1]);
      mem_lb_n  <= !(sel_d && mask_nxt[0]);
      mem_dq_o  <= wdata_nxt;
      mem_dq_oe <= drv_d;
    end
  end

  AST_OE_HIGH_WHILE_WE: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_oe_n); // R5
  AST_DRIVE_INSIDE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (!mem_we_n && $past(!mem_we_n))); // R6
  AST_NO_DRIVE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!mem_oe_n) |-> !mem_dq_oe); // R9
  AST_LANE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_cs_n |-> !(mem_ub_n && mem_lb_n)); // R8

endmodule

// File: rtl/sram_bus_ctrl.sv
module sram_bus_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W    = 18,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned CLK_PS    = 5000,
  parameter int unsigned T_RC_PS   = 10000,
  parameter int unsigned T_AA_PS   = 10000,
  parameter int unsigned T_OE_PS   = 5000,
  parameter int unsigned T_WP_PS   = 8000,
  parameter int unsigned T_DW_PS   = 5000,
  parameter int unsigned T_HZ_PS   = 5000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [1:0]        req_mask,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic              mem_ub_n,
  output logic              mem_lb_n,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_i
);

  localparam int unsigned LANE_W   = DATA_W / 2;
  localparam int unsigned RD_CYC   = max2(max2(cyc_ceil(T_RC_PS, CLK_PS), cyc_ceil(T_AA_PS, CLK_PS)),
                                          cyc_ceil(T_OE_PS, CLK_PS));
  // Driver starts one cycle into the pulse, then needs the data setup time.
  localparam int unsigned WP_CYC   = max2(cyc_ceil(T_WP_PS, CLK_PS), 1 + cyc_ceil(T_DW_PS, CLK_PS));
  localparam int unsigned TURN_CYC = max2(cyc_ceil(T_HZ_PS, CLK_PS), 1);
  localparam int unsigned TMR_W    = $clog2(max2(RD_CYC, WP_CYC) + 1);
  localparam int unsigned TURN_W   = $clog2(TURN_CYC + 1);
  localparam int unsigned PCNT_W   = $clog2(WP_CYC + 2);

  phase_e            phase_q, phase_d;
  logic              tmr_load, tmr_expired;
  logic [TMR_W-1:0]  tmr_val;
  logic [TURN_W-1:0] turn_q;
  logic [ADDR_W-1:0] lat_addr, fld_addr;
  logic [DATA_W-1:0] lat_wdata, fld_wdata;
  logic [1:0]        lat_mask, fld_mask;
  logic              is_idle, read_end;

  assign is_idle  = (phase_q == PH_IDLE);
  assign read_end = (phase_q == PH_READ) && tmr_expired;

  always_comb begin
    phase_d  = phase_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (phase_q)
      PH_IDLE: begin
        if (req_valid) begin
          if (req_mask == 2'b00) begin
            phase_d = PH_DONE;
          end else if (!req_write) begin
            phase_d  = PH_READ;
            tmr_load = 1'b1;
            tmr_val  = TMR_W'(RD_CYC - 1);
          end else if (turn_q == '0) begin
            phase_d = PH_WSETUP;
          end
        end
      end
      PH_READ:   if (tmr_expired) phase_d = PH_DONE;
      PH_WSETUP: begin
        phase_d  = PH_WPULSE;
        tmr_load = 1'b1;
        tmr_val  = TMR_W'(WP_CYC - 1);
      end
      PH_WPULSE: if (tmr_expired) phase_d = PH_WHOLD;
      PH_WHOLD:  phase_d = PH_DONE;
      PH_DONE:   phase_d = PH_IDLE;
      default:   phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_IDLE;
    else        phase_q <= phase_d;
  end

  // Guard interval owed by a write after a read.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     turn_q <= '0;
    else if (read_end)              turn_q <= TURN_W'(TURN_CYC);
    else if (is_idle && turn_q != '0) turn_q <= turn_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_addr  <= '0;
      lat_wdata <= '0;
      lat_mask  <= '0;
    end else if (is_idle && phase_d != PH_IDLE) begin
      lat_addr  <= req_addr;
      lat_wdata <= req_wdata;
      lat_mask  <= req_mask;
    end
  end

  assign fld_addr  = is_idle ? req_addr  : lat_addr;
  assign fld_wdata = is_idle ? req_wdata : lat_wdata;
  assign fld_mask  = is_idle ? req_mask  : lat_mask;

  sram_phase_timer #(.W(TMR_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  sram_pin_driver #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
    .clk             (clk),
    .rst_n           (rst_n),
    .phase_nxt       (phase_d),
    .pulse_first_nxt (phase_q == PH_WSETUP),
    .addr_nxt        (fld_addr),
    .wdata_nxt       (fld_wdata),
    .mask_nxt        (fld_mask),
    .mem_addr        (mem_addr),
    .mem_cs_n        (mem_cs_n),
    .mem_oe_n        (mem_oe_n),
    .mem_we_n        (mem_we_n),
    .mem_ub_n        (mem_ub_n),
    .mem_lb_n        (mem_lb_n),
    .mem_dq_o        (mem_dq_o),
    .mem_dq_oe       (mem_dq_oe)
  );

  sram_lane_capture #(.LANES(2), .LANE_W(LANE_W)) u_capture (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_en   (read_end),
    .lane_en  (lat_mask),
    .dq_in    (mem_dq_i),
    .data_out (rsp_rdata)
  );

  assign req_ready = (phase_q == PH_DONE);

  // Length of the current write-enable pulse, saturating.
  logic [PCNT_W-1:0] we_lo_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 we_lo_cnt <= '0;
    else if (mem_we_n)          we_lo_cnt <= '0;
    else if (we_lo_cnt != '1)   we_lo_cnt <= we_lo_cnt + 1'b1;
  end

  AST_READY_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |=> !req_ready); // R2
  AST_DESELECT_AT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> mem_cs_n); // R10
  AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (we_lo_cnt == PCNT_W'(WP_CYC))); // R5

endmodule

// File: tb/tb_sram_bus_ctrl.sv
module tb_sram_bus_ctrl;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int CLK_PS   = 5000;
  localparam int RD_CYC   = (10000 + CLK_PS - 1) / CLK_PS;
  localparam int WP_A     = (8000 + CLK_PS - 1) / CLK_PS;
  localparam int WP_B     = 1 + (5000 + CLK_PS - 1) / CLK_PS;
  localparam int WP_CYC   = (WP_A > WP_B) ? WP_A : WP_B;
  localparam int TURN_CYC = (5000 + CLK_PS - 1) / CLK_PS;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [17:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_mask = '0;
  logic        req_ready;
  logic [15:0] rsp_rdata;
  logic [17:0] mem_addr;
  logic        mem_cs_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n, mem_dq_oe;
  logic [15:0] mem_dq_o, mem_dq_i;

  always #2.5 clk = ~clk;

  sram_bus_ctrl dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_mask(req_mask), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_ub_n(mem_ub_n), .mem_lb_n(mem_lb_n), .mem_dq_o(mem_dq_o),
    .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
  );

  function automatic logic [15:0] seed_word(input int i);
    return 16'(i * 16'h0125) ^ 16'hC3C3;
  endfunction

  // Memory model, indexed by the low address byte.
  logic [15:0] cells [256];
  logic [15:0] shadow [256];
  wire mem_drv = !mem_cs_n && !mem_oe_n && mem_we_n;
  assign mem_dq_i = mem_drv ?
    {mem_ub_n ? 8'hA5 : cells[mem_addr[7:0]][15:8], mem_lb_n ? 8'h5A : cells[mem_addr[7:0]][7:0]} :
    16'hDEAD;

  int tests = 0, fails = 0, mon_tests = 0, mon_fails = 0;
  int we_run = 0, dq_run = 0, since_oe = 1000, cs_total = 0;
  logic prev_we_low = 1'b0;
  logic [17:0] cur_addr = '0;

  always @(negedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) cells[i] <= seed_word(i);
    end else begin
      if (!mem_cs_n && !mem_we_n && mem_dq_oe) begin
        if (!mem_ub_n) cells[mem_addr[7:0]][15:8] <= mem_dq_o[15:8];
        if (!mem_lb_n) cells[mem_addr[7:0]][7:0]  <= mem_dq_o[7:0];
      end
      if (!mem_we_n && !mem_oe_n) begin
        mon_tests++; mon_fails++;
        $display("FAIL R5 oe low during write act=%b exp=1", mem_oe_n);
      end
      if (mem_dq_oe && !(!mem_we_n && prev_we_low)) begin
        mon_tests++; mon_fails++;
        $display("FAIL R6 driver outside pulse act we_n=%b prev_low=%b exp=0/1", mem_we_n, prev_we_low);
      end
      if (mem_drv && mem_dq_oe) begin
        mon_tests++; mon_fails++;
        $display("FAIL R9 bus contention act=1 exp=0");
      end
      if (!mem_cs_n && mem_addr != cur_addr) begin
        mon_tests++; mon_fails++;
        $display("FAIL R3/R5 address act=%h exp=%h", mem_addr, cur_addr);
      end
      if (!mem_we_n && !prev_we_low) begin
        mon_tests++;
        if (since_oe < TURN_CYC + 3) begin
          mon_fails++;
          $display("FAIL R9 read-to-write gap act=%0d exp>=%0d", since_oe, TURN_CYC + 3);
        end
      end
      if (mem_we_n && prev_we_low) begin
        mon_tests += 2;
        if (we_run != WP_CYC) begin
          mon_fails++;
          $display("FAIL R5 pulse width act=%0d exp=%0d", we_run, WP_CYC);
        end
        if (dq_run != WP_CYC - 1) begin
          mon_fails++;
          $display("FAIL R6 driver window act=%0d exp=%0d", dq_run, WP_CYC - 1);
        end
      end
      we_run      <= !mem_we_n ? we_run + 1 : 0;
      dq_run      <= mem_dq_oe ? dq_run + 1 : (!mem_we_n ? dq_run : 0);
      since_oe    <= !mem_oe_n ? 1 : ((since_oe < 1000) ? since_oe + 1 : since_oe);
      cs_total    <= cs_total + (!mem_cs_n ? 1 : 0);
      prev_we_low <= !mem_we_n;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  bit fresh = 1'b1;
  int turn_left = 0;

  task automatic xact(input bit wr, input logic [17:0] a, input logic [15:0] d, input logic [1:0] m);
    int lat, exp_lat, cs0;
    logic [15:0] exp_rd;
    exp_lat = fresh ? 0 : 1;
    if (m == 2'b00) begin
      exp_lat += 1;
      if (turn_left > 0) turn_left--;
    end else if (wr) begin
      exp_lat += WP_CYC + 3 + turn_left;
      turn_left = 0;
    end else begin
      exp_lat += RD_CYC + 1;
      turn_left = TURN_CYC;
    end
    cur_addr  = a;
    req_write = wr; req_addr = a; req_wdata = d; req_mask = m; req_valid = 1'b1;
    cs0 = cs_total;
    lat = 0;
    do begin
      @(negedge clk); #1;
      lat++;
    end while (!req_ready && lat < 60);
    chk(lat == exp_lat, wr ? "R2/R5/R9 write latency" : "R2/R3 read latency", lat, exp_lat);
    chk(mem_cs_n == 1'b1, "R10 deselect at ready", mem_cs_n, 1);
    if (m == 2'b00) begin
      chk(cs_total == cs0, "R8 zero mask pins idle", cs_total - cs0, 0);
    end else if (wr) begin
      if (m[1]) shadow[a[7:0]][15:8] = d[15:8];
      if (m[0]) shadow[a[7:0]][7:0]  = d[7:0];
    end else begin
      exp_rd = {m[1] ? shadow[a[7:0]][15:8] : 8'h00, m[0] ? shadow[a[7:0]][7:0] : 8'h00};
      chk(rsp_rdata == exp_rd, (m == 2'b11) ? "R3/R7 read data" : "R4/R7 lane zero fill",
          rsp_rdata, exp_rd);
    end
    fresh = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) shadow[i] = seed_word(i);
    repeat (3) @(negedge clk);
    #1;
    // R1: reset values
    chk({mem_cs_n, mem_we_n, mem_oe_n, mem_ub_n, mem_lb_n, mem_dq_oe, req_ready} == 7'b1111100,
        "R1 pins in reset", {mem_cs_n, mem_we_n, mem_oe_n, mem_ub_n, mem_lb_n, mem_dq_oe, req_ready}, 7'b1111100);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    chk({mem_cs_n, mem_we_n, mem_oe_n, mem_ub_n, mem_lb_n, mem_dq_oe, req_ready} == 7'b1111100,
        "R1 pins after reset", {mem_cs_n, mem_we_n, mem_oe_n, mem_ub_n, mem_lb_n, mem_dq_oe, req_ready}, 7'b1111100);
    for (int i = 0; i < 32; i++) begin
      logic [17:0] a;
      a = 18'(i * 18'h04C93);
      xact(1'b1, a, 16'(i * 16'h3A7) ^ 16'h0F0F, 2'b11);
      for (int m = 0; m < 4; m++) begin
        xact(1'b1, a, 16'(i * 16'h3A7 + m * 16'h1111) ^ 16'hF00D, 2'(m));
        for (int r = 0; r < 4; r++) xact(1'b0, a, 16'h0000, 2'(r));
      end
    end
    req_valid = 1'b0;
    repeat (4) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests + mon_tests, fails + mon_fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog act=timeout exp=done");
    $display("[TB] %0d tests run, %0d failed", tests + mon_tests + 1, fails + mon_fails + 1);
    $finish;
  end

endmodule